// File: doc/BRIEF.md
# BCD Up/Down Decade Counter

This block holds one decimal digit as a 4-bit binary-coded value and steps it up or down by one on rising clock edges. Stepping takes place only while the active-low enable is asserted and the parallel load is idle. A parallel load copies a 4-bit digit into the counter, and the output shows that digit for as long as the load is held high. An active-high reset clears the counter at once and takes precedence over every other input.

An active-low terminal-count output marks the last value in the current direction while counting is enabled. It is combinational, so it can drive the enable of the next, more significant decade in a chain that shares one clock. The six codes above nine can appear only through a load. The counter leaves them within one count when stepping up and within two counts when stepping down.

All control and data pins are plain levels. There is no handshake, because the counter accepts a new input state on every cycle.

Top module: `bcd_decade_counter`

## Requirements
- R1: While `rst` is high, `q` reads 0000 without waiting for a clock edge, whatever `ld` and `din` are doing. The stored count and the recovery state are cleared.
- R2: While `ld` is high and `rst` is low, `q` equals `din` in the same cycle, independent of `clk`, `en_n` and `up`. The value present on the last rising edge of the load remains in `q` after `ld` falls.
- R3: When `ld` is low, `q` changes only on a rising edge of `clk` at which `en_n` is low. When `en_n` is high, `q` holds across any number of edges.
- R4: Stepping up (`up` = 1) adds one to the digit, and 9 is followed by 0.
- R5: Stepping down (`up` = 0) subtracts one from the digit, and 0 is followed by 9.
- R6: With `up` = 1, `tc_n` is low exactly when `q[0]` and `q[3]` are both 1 and `en_n` is low.
- R7: With `up` = 0, `tc_n` is low exactly when `q` is 0000 and `en_n` is low.
- R8: `tc_n` is high whenever `en_n` is high, for any digit and any direction.
- R9: Stepping up from any code from 10 to 15 gives 0.
- R10: Stepping down from a code from 10 to 15 first gives that code minus one, so 10 gives 9. If the result is still above 9, the next down step gives 9. A load or reset cancels this pending correction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge |
| rst | input | 1 | Asynchronous clear, active high, overrides everything |
| ld | input | 1 | Parallel load, active high |
| din | input | 4 | Digit to load |
| en_n | input | 1 | Count enable, active low |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| q | output | 4 | Current digit |
| tc_n | output | 1 | Terminal count, active low |

## Verification
Each step result is due after exactly one rising edge, since one register lies between the step inputs and `q`. The bench changes inputs on the falling edge and samples `q` on the following falling edge. The reset clear, the load bypass and `tc_n` have no register in their path. The bench checks them one time unit after it changes the input that drives them, before any clock edge falls due. Recovery from illegal codes in the down direction takes two steps, and the bench checks the value after each of those edges.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
  localparam int DIGIT_W = 4;
  localparam int LAST_DIGIT = 9;
  typedef logic [DIGIT_W-1:0] digit_t;
  localparam digit_t DIGIT_LAST = digit_t'(LAST_DIGIT);
  localparam digit_t DIGIT_ZERO = '0;
endpackage

// File: rtl/bcd_cnt_step.sv
module bcd_cnt_step
  import bcd_cnt_pkg::*;
(
  input  digit_t cur,
  input  logic   up,
  input  logic   pend,
  output digit_t nxt,
  output logic   nxt_pend
);
  logic illegal;
  assign illegal = (cur > DIGIT_LAST);

  always_comb begin
    if (up) begin
      nxt = (cur >= DIGIT_LAST) ? DIGIT_ZERO : cur + digit_t'(1);
    end else if (cur == DIGIT_ZERO) begin
      nxt = DIGIT_LAST;
    end else if (illegal && pend) begin
      nxt = DIGIT_LAST;
    end else begin
      nxt = cur - digit_t'(1);
    end
    nxt_pend = !up && (nxt > DIGIT_LAST);
  end

  always_comb begin
    assert_step_legal_up_R9: assert (!up || nxt <= DIGIT_LAST);
  end
endmodule

// File: rtl/bcd_cnt_tc.sv
module bcd_cnt_tc
  import bcd_cnt_pkg::*;
(
  input  digit_t q,
  input  logic   en_n,
  input  logic   up,
  output logic   tc_n
);
  logic at_end;
  assign at_end = up ? (q[0] && q[DIGIT_W-1]) : (q == DIGIT_ZERO);
  assign tc_n   = !(at_end && !en_n);

  always_comb begin
    if (en_n) assert_tc_idle_R8: assert (tc_n);
  end
endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
  import bcd_cnt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ld,
  input  logic [DIGIT_W-1:0] din,
  input  logic               en_n,
  input  logic               up,
  output logic [DIGIT_W-1:0] q,
  output logic               tc_n
);
  digit_t cnt_q, nxt;
  logic   pend_q, nxt_pend;

  bcd_cnt_step u_step (
    .cur(cnt_q), .up(up), .pend(pend_q), .nxt(nxt), .nxt_pend(nxt_pend)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt_q  <= DIGIT_ZERO;
      pend_q <= 1'b0;
    end else if (ld) begin
      cnt_q  <= din;
      pend_q <= 1'b0;
    end else if (!en_n) begin
      cnt_q  <= nxt;
      pend_q <= nxt_pend;
    end
  end

  assign q = rst ? DIGIT_ZERO : (ld ? din : cnt_q);

  bcd_cnt_tc u_tc (.q(q), .en_n(en_n), .up(up), .tc_n(tc_n));

  always_comb begin
    if (rst) assert_reset_clear_R1: assert (q == DIGIT_ZERO);
  end

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
    ld |=> cnt_q == $past(din));

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!ld && en_n) |=> $stable(cnt_q));

  assert_up_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (!ld && !en_n && up && cnt_q == DIGIT_LAST) |=> cnt_q == DIGIT_ZERO);

  assert_down_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (!ld && !en_n && !up && cnt_q == DIGIT_ZERO) |=> cnt_q == DIGIT_LAST);

  assert_down_second_R10: assert property (@(posedge clk) disable iff (rst)
    (!ld && !en_n && !up && pend_q && cnt_q > DIGIT_LAST) |=> cnt_q == DIGIT_LAST);
endmodule

// File: tb/bcd_decade_counter_bench.sv
module bcd_decade_counter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld = 1'b0;
  logic [3:0] din = 4'd0;
  logic       en_n = 1'b1;
  logic       up = 1'b1;
  logic [3:0] q;
  logic       tc_n;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd_decade_counter u_bcd_decade_counter (
    .clk(clk), .rst(rst), .ld(ld), .din(din), .en_n(en_n), .up(up),
    .q(q), .tc_n(tc_n)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_digit(input logic [3:0] v);
    ld = 1'b1; din = v;
    tick();
    ld = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk(q, 0, "R1 q at reset");
    chk(tc_n, 1, "R8 tc_n at reset with enable off");
    @(negedge clk); rst = 1'b0;
    load_digit(4'd6);
    ld = 1'b1; din = 4'd3; rst = 1'b1; #1;
    chk(q, 0, "R1 reset overrides load");
    @(negedge clk); rst = 1'b0; ld = 1'b0; #1;
    chk(q, 0, "R1 count cleared");
  endtask

  task automatic t_load();
    @(negedge clk);
    ld = 1'b1; din = 4'd7; en_n = 1'b0; up = 1'b0; #1;
    chk(q, 7, "R2 bypass before edge");
    tick(); tick();
    chk(q, 7, "R2 load beats counting");
    ld = 1'b0; en_n = 1'b1; #1;
    chk(q, 7, "R2 kept after load");
  endtask

  task automatic t_hold();
    load_digit(4'd4);
    en_n = 1'b1; up = 1'b1;
    for (int i = 0; i < 3; i++) tick();
    chk(q, 4, "R3 hold with enable off");
    en_n = 1'b0; #3;
    chk(q, 4, "R3 no change without edge");
    en_n = 1'b1;
  endtask

  task automatic t_up();
    load_digit(4'd8);
    up = 1'b1; en_n = 1'b0; #1;
    chk(tc_n, 1, "R6 tc_n high at 8 up");
    tick(); chk(q, 9, "R4 8 to 9");
    chk(tc_n, 0, "R6 tc_n low at 9 up");
    tick(); chk(q, 0, "R4 9 wraps to 0");
    tick(); chk(q, 1, "R4 0 to 1");
    en_n = 1'b1;
  endtask

  task automatic t_down();
    load_digit(4'd2);
    up = 1'b0; en_n = 1'b0;
    tick(); chk(q, 1, "R5 2 to 1");
    chk(tc_n, 1, "R7 tc_n high at 1 down");
    tick(); chk(q, 0, "R5 1 to 0");
    chk(tc_n, 0, "R7 tc_n low at 0 down");
    up = 1'b1; #1;
    chk(tc_n, 1, "R6 tc_n high at 0 up");
    up = 1'b0;
    tick(); chk(q, 9, "R5 0 wraps to 9");
    chk(tc_n, 1, "R7 tc_n high at 9 down");
    en_n = 1'b1;
  endtask

  task automatic t_tc_idle();
    load_digit(4'd9);
    up = 1'b1; en_n = 1'b1; #1;
    chk(tc_n, 1, "R8 tc_n at 9 up idle");
    load_digit(4'd0);
    up = 1'b0; #1;
    chk(tc_n, 1, "R8 tc_n at 0 down idle");
  endtask

  task automatic t_up_illegal();
    for (int v = 10; v < 16; v++) begin
      load_digit(4'(v));
      up = 1'b1; en_n = 1'b0; #1;
      if (v == 11) chk(tc_n, 0, "R6 tc_n low at 11 up");
      tick();
      chk(q, 0, $sformatf("R9 up from %0d", v));
      en_n = 1'b1;
    end
  endtask

  task automatic t_down_illegal();
    load_digit(4'd10);
    up = 1'b0; en_n = 1'b0;
    tick(); chk(q, 9, "R10 10 down to 9");
    en_n = 1'b1;
    load_digit(4'd15);
    en_n = 1'b0;
    tick(); chk(q, 14, "R10 15 down to 14");
    tick(); chk(q, 9, "R10 14 forced to 9");
    en_n = 1'b1;
    load_digit(4'd11);
    en_n = 1'b0;
    tick(); chk(q, 10, "R10 11 down to 10");
    tick(); chk(q, 9, "R10 10 to 9");
    en_n = 1'b1;
    load_digit(4'd13);
    en_n = 1'b0;
    tick(); chk(q, 12, "R10 13 down to 12");
    en_n = 1'b1;
    load_digit(4'd12);
    en_n = 1'b0;
    tick(); chk(q, 11, "R10 load cancels pending");
    en_n = 1'b1;
  endtask

  initial begin
    #1;
    t_reset();
    t_load();
    t_hold();
    t_up();
    t_down();
    t_tc_idle();
    t_up_illegal();
    t_down_illegal();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule